// File: doc/BRIEF.md
# Card command type override and response capture

This block sits between the software view of a memory-card host and the serial engine that drives the card bus. Software writes a command word: a 6-bit index, a 32-bit argument, a 2-bit command-type correction, a 3-bit response-type correction and a valid flag. The block holds a built-in default pair (command type, response type) for each of the 64 indices. It XORs the corrections into those defaults, so software only flips the bits where a card family departs from the built-in assumption. It then presents the command with its effective types on an issue port for one cycle.

While the command is in flight, the block waits for the response. The response is delivered on a stimulus port in place of the serial engine, together with CRC-error and timeout indications. It places the response bits into a low and a high 64-bit register according to the effective response type. It reports validity, type, CRC, timeout and card-status errors in a status word, and raises a done or error interrupt bit that software clears by writing ones.

Top module: `card_cmd_typer`

## Requirements
- R1: After a synchronous active-low reset, busy, iss_valid, all status flags, both interrupt bits, sts_rsp_type and both response registers are zero.
- R2: The effective command type is the default command type XOR cmd_ctype_xor, and the effective response type is the default response type XOR cmd_rtype_xor. Command type codes are 0 no data, 1 read, 2 write. Response type codes are 0 none, 1 short 48-bit, 2 long 136-bit, 3 short with no CRC check. Defaults (command, response) include: index 0 (0,0), index 1 (0,3), index 2 (0,2), index 17 (1,1), index 24 (2,1), index 39 (0,4), index 56 (3,7).
- R3: A write with cmd_wr=1 and cmd_valid=1 while not busy is accepted at that clock edge. In the next cycle iss_valid is high for exactly one cycle with the index, the argument and the effective types, busy is high, sts_rsp_type shows the effective response type, and the response-valid, CRC, timeout and bad-status flags are cleared. A write with cmd_valid=0 has no effect.
- R4: For an effective response type other than 0 and 2, a response with rsp_in_valid stores rsp_lo = 16 zero bits followed by rsp_in_bits[47:0], sets rsp_hi to zero, and sets sts_rsp_val. The 32-bit card status is then rsp_lo[39:8].
- R5: For effective response type 2, a response stores rsp_hi = rsp_in_bits[127:64] and rsp_lo = rsp_in_bits[63:0], so the most significant word lands in rsp_hi[63:32].
- R6: A command whose effective response type is 0 completes at the clock edge after the one that accepted it, with no response. busy falls, the done interrupt is set, sts_rsp_val stays 0, and the response registers keep their values.
- R7: rsp_in_crc_bad sets sts_crc_err and the error interrupt only when the effective response type is 1 or 2. For any other type it is ignored.
- R8: rsp_in_timeout while busy on a command with a response completes it with sts_timeout=1, sts_rsp_val=0, the error interrupt set and the response registers unchanged. It takes priority over rsp_in_valid in the same cycle.
- R9: For effective response type 1, a card status with any bit set in STS_ERR_MASK (default 32'hFFF8_0000) sets sts_bad_sts and the error interrupt.
- R10: A completion without CRC, bad-status or timeout error sets irq_pend[0]; any of those errors sets irq_pend[1] instead. With irq_clr_wr=1, each 1 in irq_clr[1:0] clears the matching bit. A set and a clear of the same bit at one edge leave it set.
- R11: A valid command write while busy sets the sticky sts_collide flag and is otherwise ignored: no iss_valid, and busy and the issued fields are unchanged. irq_clr_wr with irq_clr[2]=1 clears sts_collide.
- R12: rsp_in_valid, rsp_in_crc_bad and rsp_in_timeout while not busy change no register, status flag or interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_valid | input | 1 | Valid flag of the written command word |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_ctype_xor | input | 2 | Command-type correction |
| cmd_rtype_xor | input | 3 | Response-type correction |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_idx | output | 6 | Issued index |
| iss_arg | output | 32 | Issued argument |
| iss_ctype | output | 2 | Effective command type |
| iss_rtype | output | 3 | Effective response type |
| busy | output | 1 | Command in flight |
| rsp_in_valid | input | 1 | Response delivered |
| rsp_in_bits | input | 128 | Response bits (short uses [47:0]) |
| rsp_in_crc_bad | input | 1 | Response CRC mismatch |
| rsp_in_timeout | input | 1 | No response within the allowed time |
| rsp_lo | output | 64 | Low response register |
| rsp_hi | output | 64 | High response register |
| sts_rsp_val | output | 1 | Response stored |
| sts_rsp_type | output | 3 | Effective response type of the last accepted command |
| sts_crc_err | output | 1 | CRC error on last response |
| sts_timeout | output | 1 | Last command timed out |
| sts_bad_sts | output | 1 | Card status reported an error |
| sts_collide | output | 1 | Sticky: write made while busy |
| irq_pend | output | 2 | Interrupt bits: [0] done, [1] error |
| irq_clr_wr | input | 1 | Interrupt clear strobe |
| irq_clr | input | 3 | Write-one-to-clear mask: [0] done, [1] error, [2] collision |

## Verification
The hardest situations to reach are the ones where two events meet at one clock edge. These are a timeout arriving together with a response, a completion landing on the same edge as a software clear of its interrupt bit, and a second command written while the first is still waiting. The stimulus creates each collision directly by driving both inputs in the same cycle. Coverage of the type logic comes from a sweep over every index with every pair of corrections. The sweep learns each default from the zero-correction issue and checks every other correction against it arithmetically. It also pins the listed defaults and completes every command with computed response bits, so CRC masking and card-status errors occur across all response types.

// File: rtl/cct_pkg.sv
// Shared types and the built-in default type table for the command typer.
// Assumes a 6-bit command index; the table is computed by a function.
package cct_pkg;

    localparam int IDX_W = 6;
    localparam int CT_W  = 2;
    localparam int RT_W  = 3;

    typedef logic [CT_W-1:0] ctype_t;
    typedef logic [RT_W-1:0] rtype_t;

    typedef struct packed {
        ctype_t ct;
        rtype_t rt;
    } cr_pair_t;

    // Default command/response type pair for a command index.
    function automatic cr_pair_t cct_default(input logic [IDX_W-1:0] idx);
        cr_pair_t p;
        p.ct = 2'd0;
        p.rt = 3'd0;
        case (idx) inside
            6'd8, 6'd11, 6'd14, 6'd17, 6'd18, 6'd30, 6'd31: p.ct = 2'd1;
            6'd20, [6'd24:6'd27], 6'd42:                    p.ct = 2'd2;
            6'd19, 6'd56:                                   p.ct = 2'd3;
            default:                                        p.ct = 2'd0;
        endcase
        case (idx) inside
            6'd1:                                           p.rt = 3'd3;
            6'd2, 6'd9, 6'd10:                              p.rt = 3'd2;
            6'd39:                                          p.rt = 3'd4;
            6'd40:                                          p.rt = 3'd5;
            6'd56:                                          p.rt = 3'd7;
            6'd3, [6'd5:6'd8], [6'd11:6'd14], [6'd16:6'd20],
            [6'd23:6'd31], 6'd35, 6'd36, 6'd38, 6'd42, 6'd55: p.rt = 3'd1;
            default:                                        p.rt = 3'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cct_defaults_lut.sv
// Looks up the default type pair and applies the software XOR corrections.
// Purely combinational; assumes the index is already 6 bits wide.
module cct_defaults_lut
    import cct_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  ctype_t           ct_xor,
    input  rtype_t           rt_xor,
    output ctype_t           eff_ct,
    output rtype_t           eff_rt
);
    cr_pair_t dflt;

    // Table lookup followed by the XOR correction.
    always_comb begin
        dflt   = cct_default(idx);
        eff_ct = dflt.ct ^ ct_xor;
        eff_rt = dflt.rt ^ rt_xor;
    end
endmodule

// File: rtl/cct_rsp_pack.sv
// Arranges raw response bits into the low/high response register images and
// extracts the card status of a short response. Combinational only.
module cct_rsp_pack #(
    parameter int RSP_W   = 64,
    parameter int SHORT_W = 48,
    parameter int STAT_LSB = 8,
    parameter int STAT_W  = 32
) (
    input  logic               is_long,
    input  logic [2*RSP_W-1:0] bits,
    output logic [RSP_W-1:0]   lo_img,
    output logic [RSP_W-1:0]   hi_img,
    output logic [STAT_W-1:0]  card_status
);
    localparam int PAD_W = RSP_W - SHORT_W;

    // Long responses fill both registers; short ones sit zero-extended in lo.
    always_comb begin
        if (is_long) begin
            hi_img = bits[2*RSP_W-1:RSP_W];
            lo_img = bits[RSP_W-1:0];
        end else begin
            hi_img = '0;
            lo_img = {{PAD_W{1'b0}}, bits[SHORT_W-1:0]};
        end
        card_status = bits[STAT_LSB+STAT_W-1:STAT_LSB];
    end
endmodule

// File: rtl/cct_irq_latch.sv
// Bank of sticky event bits with write-one-to-clear; a set beats a clear.
module cct_irq_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // One sticky bit: reset, set priority, then software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set[g])
                pend[g] <= 1'b1;
            else if (clr_wr && clr[g])
                pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/card_cmd_typer.sv
// Command issue and response capture with per-index default types corrected
// by XOR. Assumes one command in flight; the response arrives on a port.
module card_cmd_typer
    import cct_pkg::*;
#(
    parameter int          ARG_W        = 32,
    parameter int          RSP_W        = 64,
    parameter int          STAT_W       = 32,
    parameter logic [31:0] STS_ERR_MASK = 32'hFFF8_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_valid,
    input  logic [5:0]         cmd_idx,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic [1:0]         cmd_ctype_xor,
    input  logic [2:0]         cmd_rtype_xor,
    output logic               iss_valid,
    output logic [5:0]         iss_idx,
    output logic [ARG_W-1:0]   iss_arg,
    output logic [1:0]         iss_ctype,
    output logic [2:0]         iss_rtype,
    output logic               busy,
    input  logic               rsp_in_valid,
    input  logic [2*RSP_W-1:0] rsp_in_bits,
    input  logic               rsp_in_crc_bad,
    input  logic               rsp_in_timeout,
    output logic [RSP_W-1:0]   rsp_lo,
    output logic [RSP_W-1:0]   rsp_hi,
    output logic               sts_rsp_val,
    output logic [2:0]         sts_rsp_type,
    output logic               sts_crc_err,
    output logic               sts_timeout,
    output logic               sts_bad_sts,
    output logic               sts_collide,
    output logic [1:0]         irq_pend,
    input  logic               irq_clr_wr,
    input  logic [2:0]         irq_clr
);
    localparam int     N_EVT   = 3;
    localparam rtype_t RT_NONE = 3'd0;
    localparam rtype_t RT_R1   = 3'd1;
    localparam rtype_t RT_LONG = 3'd2;

    ctype_t            eff_ct;
    rtype_t            eff_rt;
    logic [RSP_W-1:0]  lo_img, hi_img;
    logic [STAT_W-1:0] card_status;
    logic              accept, collide;
    logic              comp_nil, comp_to, comp_rsp;
    logic              crc_hit, bad_hit, set_done, set_err;
    logic [N_EVT-1:0]  evt_pend;

    cct_defaults_lut u_lut (
        .idx    (cmd_idx),
        .ct_xor (cmd_ctype_xor),
        .rt_xor (cmd_rtype_xor),
        .eff_ct (eff_ct),
        .eff_rt (eff_rt)
    );

    cct_rsp_pack #(.RSP_W(RSP_W), .STAT_W(STAT_W)) u_pack (
        .is_long     (iss_rtype == RT_LONG),
        .bits        (rsp_in_bits),
        .lo_img      (lo_img),
        .hi_img      (hi_img),
        .card_status (card_status)
    );

    // Decode of acceptance, completion kind and error conditions.
    always_comb begin
        accept   = cmd_wr && cmd_valid && !busy;
        collide  = cmd_wr && cmd_valid && busy;
        comp_nil = busy && (iss_rtype == RT_NONE);
        comp_to  = busy && (iss_rtype != RT_NONE) && rsp_in_timeout;
        comp_rsp = busy && (iss_rtype != RT_NONE) && !rsp_in_timeout && rsp_in_valid;
        crc_hit  = rsp_in_crc_bad && ((iss_rtype == RT_R1) || (iss_rtype == RT_LONG));
        bad_hit  = (iss_rtype == RT_R1) && ((card_status & STS_ERR_MASK) != '0);
        set_done = comp_nil || (comp_rsp && !crc_hit && !bad_hit);
        set_err  = comp_to || (comp_rsp && (crc_hit || bad_hit));
    end

    // Command state, issue fields, response registers and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            iss_valid    <= 1'b0;
            iss_idx      <= '0;
            iss_arg      <= '0;
            iss_ctype    <= '0;
            iss_rtype    <= '0;
            rsp_lo       <= '0;
            rsp_hi       <= '0;
            sts_rsp_val  <= 1'b0;
            sts_rsp_type <= '0;
            sts_crc_err  <= 1'b0;
            sts_timeout  <= 1'b0;
            sts_bad_sts  <= 1'b0;
        end else begin
            iss_valid <= accept;
            if (accept) begin
                busy         <= 1'b1;
                iss_idx      <= cmd_idx;
                iss_arg      <= cmd_arg;
                iss_ctype    <= eff_ct;
                iss_rtype    <= eff_rt;
                sts_rsp_type <= eff_rt;
                sts_rsp_val  <= 1'b0;
                sts_crc_err  <= 1'b0;
                sts_timeout  <= 1'b0;
                sts_bad_sts  <= 1'b0;
            end else if (comp_nil) begin
                busy <= 1'b0;
            end else if (comp_to) begin
                busy        <= 1'b0;
                sts_timeout <= 1'b1;
            end else if (comp_rsp) begin
                busy        <= 1'b0;
                rsp_lo      <= lo_img;
                rsp_hi      <= hi_img;
                sts_rsp_val <= 1'b1;
                sts_crc_err <= crc_hit;
                sts_bad_sts <= bad_hit;
            end
        end
    end

    cct_irq_latch #(.N(N_EVT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    ({collide, set_err, set_done}),
        .clr_wr (irq_clr_wr),
        .clr    (irq_clr),
        .pend   (evt_pend)
    );

    assign irq_pend    = evt_pend[1:0];
    assign sts_collide = evt_pend[2];

endmodule

// File: rtl/cct_checker.sv
// Temporal checks on the command typer, attached by bind below.
module cct_checker #(
    parameter int RSP_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic               cmd_valid,
    input logic               iss_valid,
    input logic [2:0]         iss_rtype,
    input logic               busy,
    input logic               rsp_in_valid,
    input logic [2*RSP_W-1:0] rsp_in_bits,
    input logic               rsp_in_timeout,
    input logic [RSP_W-1:0]   rsp_lo,
    input logic [RSP_W-1:0]   rsp_hi,
    input logic               sts_rsp_val,
    input logic               sts_timeout,
    input logic               sts_collide,
    input logic [1:0]         irq_pend
);
    a_r3_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_valid && !busy) |=> (busy && iss_valid));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid);

    a_r11_collide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_valid && busy) |=> (sts_collide && !iss_valid));

    a_r8_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iss_rtype != 3'd0 && rsp_in_timeout)
        |=> (!busy && sts_timeout && !sts_rsp_val && irq_pend[1]));

    a_r5_long_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iss_rtype == 3'd2 && rsp_in_valid && !rsp_in_timeout)
        |=> (rsp_hi == $past(rsp_in_bits[2*RSP_W-1:RSP_W])));

    a_r6_no_response: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iss_rtype == 3'd0) |=> (!busy && irq_pend[0] && !sts_rsp_val));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_wr && cmd_valid))
        |=> ($stable(rsp_lo) && $stable(rsp_hi) && $stable(sts_rsp_val)));
endmodule

bind card_cmd_typer cct_checker #(.RSP_W(RSP_W)) u_cct_checker (.*);

// File: tb/test_card_cmd_typer.sv
`timescale 1ns/1ps
module test_card_cmd_typer;
    localparam logic [31:0] MASK = 32'hFFF8_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 0, cmd_valid = 0;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   cmd_ctype_xor = '0;
    logic [2:0]   cmd_rtype_xor = '0;
    logic         iss_valid;
    logic [5:0]   iss_idx;
    logic [31:0]  iss_arg;
    logic [1:0]   iss_ctype;
    logic [2:0]   iss_rtype;
    logic         busy;
    logic         rsp_in_valid = 0, rsp_in_crc_bad = 0, rsp_in_timeout = 0;
    logic [127:0] rsp_in_bits = '0;
    logic [63:0]  rsp_lo, rsp_hi;
    logic         sts_rsp_val, sts_crc_err, sts_timeout, sts_bad_sts, sts_collide;
    logic [2:0]   sts_rsp_type;
    logic [1:0]   irq_pend;
    logic         irq_clr_wr = 0;
    logic [2:0]   irq_clr = '0;

    int n_vec = 0;
    int n_bad = 0;
    logic [1:0] base_ct [64];
    logic [2:0] base_rt [64];

    always #2.5 clk = ~clk;

    card_cmd_typer i_card_cmd_typer (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] cx, input logic [2:0] rx, input logic v);
        @(negedge clk);
        cmd_wr = 1; cmd_valid = v; cmd_idx = idx; cmd_arg = arg;
        cmd_ctype_xor = cx; cmd_rtype_xor = rx;
        @(negedge clk);
        cmd_wr = 0; cmd_valid = 0;
    endtask

    task automatic respond(input logic v, input logic to, input logic crc, input logic [127:0] b);
        rsp_in_valid = v; rsp_in_timeout = to; rsp_in_crc_bad = crc; rsp_in_bits = b;
        @(negedge clk);
        rsp_in_valid = 0; rsp_in_timeout = 0; rsp_in_crc_bad = 0;
    endtask

    task automatic clear_irq(input logic [2:0] m);
        irq_clr_wr = 1; irq_clr = m;
        @(negedge clk);
        irq_clr_wr = 0; irq_clr = '0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL all watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] bits;
        logic [63:0]  old_lo, old_hi;
        logic [2:0]   eff;
        logic         crc, exp_crc, exp_bad, err;
        logic [31:0]  x;
        int           vid;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 iss_valid", iss_valid, 0);
        chk("R1 status", {sts_rsp_val, sts_crc_err, sts_timeout, sts_bad_sts, sts_collide, sts_rsp_type}, 0);
        chk("R1 irq", irq_pend, 0);
        chk("R1 rsp", {rsp_hi, rsp_lo}, 0);

        // R3: a write without the valid flag does nothing
        issue(6'd5, 32'h1, 2'd0, 3'd0, 1'b0);
        chk("R3 invalid write no issue", {iss_valid, busy}, 0);

        // Full sweep: every index with every correction pair
        vid = 0;
        for (int idx = 0; idx < 64; idx++) begin
            for (int cx = 0; cx < 4; cx++) begin
                for (int rx = 0; rx < 8; rx++) begin
                    vid++;
                    x = 32'h9E37_79B9 * vid;
                    old_lo = rsp_lo; old_hi = rsp_hi;
                    issue(idx[5:0], x, cx[1:0], rx[2:0], 1'b1);
                    chk("R3 issue strobe", {iss_valid, busy}, 2'b11);
                    chk("R3 issue fields", {iss_idx, iss_arg}, {idx[5:0], x});
                    chk("R3 status cleared", {sts_rsp_val, sts_crc_err, sts_timeout, sts_bad_sts}, 0);
                    if (cx == 0 && rx == 0) begin
                        base_ct[idx] = iss_ctype;
                        base_rt[idx] = iss_rtype;
                    end else begin
                        chk("R2 ctype xor", iss_ctype, base_ct[idx] ^ cx[1:0]);
                        chk("R2 rtype xor", iss_rtype, base_rt[idx] ^ rx[2:0]);
                    end
                    eff = base_rt[idx] ^ rx[2:0];
                    chk("R3 sts_rsp_type", sts_rsp_type, eff);
                    if (eff == 3'd0) begin
                        @(negedge clk);
                        chk("R6 complete no response", {busy, irq_pend, sts_rsp_val}, {1'b0, 2'b01, 1'b0});
                        chk("R6 regs kept", {rsp_hi, rsp_lo}, {old_hi, old_lo});
                    end else begin
                        bits = {x, x ^ 32'h5A5A_5A5A, ~x, x + 32'h0123_4567};
                        crc = idx[0] ^ rx[0];
                        respond(1'b1, 1'b0, crc, bits);
                        exp_crc = crc && (eff == 3'd1 || eff == 3'd2);
                        exp_bad = (eff == 3'd1) && ((bits[39:8] & MASK) != 0);
                        err = exp_crc || exp_bad;
                        chk("R4 response valid", {busy, sts_rsp_val}, 2'b01);
                        if (eff == 3'd2)
                            chk("R5 long split", {rsp_hi, rsp_lo}, bits);
                        else
                            chk("R4 short placement", {rsp_hi, rsp_lo}, {64'h0, 16'h0, bits[47:0]});
                        chk("R7 crc flag", sts_crc_err, exp_crc);
                        chk("R9 bad status", sts_bad_sts, exp_bad);
                        chk("R10 irq kind", irq_pend, {err, !err});
                    end
                    clear_irq(3'b011);
                    chk("R10 irq cleared", irq_pend, 0);
                end
            end
        end

        // R2 pinned defaults
        chk("R2 idx0", {base_ct[0], base_rt[0]}, {2'd0, 3'd0});
        chk("R2 idx1", {base_ct[1], base_rt[1]}, {2'd0, 3'd3});
        chk("R2 idx2", {base_ct[2], base_rt[2]}, {2'd0, 3'd2});
        chk("R2 idx17", {base_ct[17], base_rt[17]}, {2'd1, 3'd1});
        chk("R2 idx24", {base_ct[24], base_rt[24]}, {2'd2, 3'd1});
        chk("R2 idx39", {base_ct[39], base_rt[39]}, {2'd0, 3'd4});
        chk("R2 idx56", {base_ct[56], base_rt[56]}, {2'd3, 3'd7});

        // R11 collision, then R8 timeout beating a simultaneous response
        old_lo = rsp_lo; old_hi = rsp_hi;
        issue(6'd17, 32'hCAFE_0001, 2'd0, 3'd0, 1'b1);
        issue(6'd24, 32'hDEAD_0002, 2'd0, 3'd0, 1'b1);
        chk("R11 collide flag", sts_collide, 1);
        chk("R11 ignored", {iss_valid, busy, iss_idx, iss_arg}, {1'b0, 1'b1, 6'd17, 32'hCAFE_0001});
        respond(1'b1, 1'b1, 1'b0, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        chk("R8 timeout outcome", {busy, sts_timeout, sts_rsp_val, irq_pend}, {1'b0, 1'b1, 1'b0, 2'b10});
        chk("R8 regs kept", {rsp_hi, rsp_lo}, {old_hi, old_lo});
        clear_irq(3'b100);
        chk("R11 collide cleared", {sts_collide, irq_pend}, {1'b0, 2'b10});
        clear_irq(3'b011);

        // R12 stimulus while idle is ignored
        old_lo = rsp_lo; old_hi = rsp_hi;
        respond(1'b1, 1'b0, 1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
        respond(1'b0, 1'b1, 1'b0, 128'h0);
        chk("R12 idle regs", {rsp_hi, rsp_lo}, {old_hi, old_lo});
        chk("R12 idle status", {busy, sts_rsp_val, sts_crc_err, sts_timeout, irq_pend}, {1'b0, 1'b0, 1'b0, 1'b1, 2'b00});

        // R10 set wins over a same-edge clear
        issue(6'd17, 32'h0000_0042, 2'd0, 3'd0, 1'b1);
        irq_clr_wr = 1; irq_clr = 3'b001;
        respond(1'b1, 1'b0, 1'b0, 128'h12AB);
        irq_clr_wr = 0; irq_clr = '0;
        chk("R10 set beats clear", irq_pend, 2'b01);
        chk("R4 short status field", rsp_lo[39:8], 32'h0000_0012);

        summary();
        $finish;
    end
endmodule